// File: doc/BRIEF.md
# Mini UART register interface

This block is the software-visible front end of a simplified UART. A processor reaches it through a 32-bit, word-only register bus covering a 256-byte window; every access is one request cycle, and read data comes back on the following cycle with a valid strobe. Incoming bytes arrive on a valid/ready byte stream and are held in a small circular receive FIFO until software reads them from the data register. Bytes written to the data register leave at once on a transmit byte output with a one-cycle strobe. The block behaves as though the transmit path is always empty and drains instantly.

Status registers are computed from the receive FIFO occupancy and the two interrupt enable bits. A single registered, level-sensitive interrupt output follows them. Serial framing, baud generation, modem lines, the scratch store and any divisor-latch mode are not part of this block. Their register slots read as zero and ignore writes.

Top module: `muart_regs`

## Requirements
- R1: After synchronous reset the receive FIFO is empty, both interrupt enables are 0, `irq` and `tx_valid` are 0 and `rx_ready` is 1.
- R2: A write to word offset 0x40 drives `tx_valid` high for exactly the next cycle, with `tx_data` equal to write data bits 7:0. No other write produces a transmit strobe.
- R3: A write to offset 0x44 keeps only bit 0 (receive enable) and bit 1 (transmit enable). A read of 0x44 returns those bits ORed with 0xC0.
- R4: A byte offered while `rx_valid` and `rx_ready` are both high is stored. Reads of offset 0x40 return the stored bytes in arrival order, each read removing one byte.
- R5: The FIFO holds up to DEPTH bytes (default 8). `rx_ready` is low exactly when it is full, and a byte offered then is not stored.
- R6: A read of 0x40 with the FIFO empty returns the entry at the current head position without moving the head or changing the count. The next byte received is then returned by the next data read.
- R7: A read of offset 0x48 returns 0xC0, plus 0x4 if the FIFO holds data or 0x2 if it is empty, plus 0x1 when no interrupt is pending.
- R8: A write to 0x48 with bit 1 set empties the FIFO. With bit 1 clear it leaves the FIFO unchanged. A flush in the same cycle as an accepted receive byte discards that byte as well.
- R9: A read of offset 0x54 returns 0x60, with bit 0 set when the FIFO holds data.
- R10: A read of offset 0x64 returns 0x30E, with bit 0 set when the FIFO holds data and the FIFO fill count in bits 16 upward.
- R11: An interrupt is pending when the receive enable is set and the FIFO is non-empty, or whenever the transmit enable is set. `irq` shows this one cycle after the state changes. A read of offset 0x00 returns 1 when an interrupt is pending and 0 otherwise.
- R12: Offset 0x04 reads 1 and offset 0x60 reads 3. Offsets 0x4C, 0x50, 0x58, 0x5C, 0x68 and every unmapped offset read 0. Writes to these offsets, and to 0x00, 0x04 and 0x60, change nothing.
- R13: Every read request gives exactly one `bus_rvalid` pulse, in the cycle after the request, carrying that read's data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address in the window (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe, one cycle after the request |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte offered |
| rx_ready | output | 1 | FIFO can accept a byte |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The bench wraps the read pointer around the circular buffer and fills it to DEPTH. A design that ignored `rx_ready` would then overwrite the oldest byte, and one that mis-wrapped the write index would return bytes out of order. Empty data reads target underflow: a faulty count would go negative, showing a huge fill level in the extended status, and a head that advanced would make the next received byte unreadable. Flushes are issued with bit 1 clear, and also together with an arriving byte, which exposes a flush that ignores the bit or loses the precedence race. The identification and interrupt encodings are checked across all four combinations of enable and occupancy, which catches swapped priority or an inverted pending bit.

// File: rtl/muart_pkg.sv
package muart_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;

  // Register word indices (byte offset >> 2)
  localparam logic [5:0] IX_IRQSUM = 6'h00;
  localparam logic [5:0] IX_ENABLE = 6'h01;
  localparam logic [5:0] IX_DATA   = 6'h10;
  localparam logic [5:0] IX_INTEN  = 6'h11;
  localparam logic [5:0] IX_INTID  = 6'h12;
  localparam logic [5:0] IX_LINEST = 6'h15;
  localparam logic [5:0] IX_CTRL   = 6'h18;
  localparam logic [5:0] IX_XSTAT  = 6'h19;

  localparam logic [WORD_W-1:0] FIFO_EN_BITS = 32'h0000_00C0;
  localparam logic [WORD_W-1:0] LINE_BASE    = 32'h0000_0060;
  localparam logic [WORD_W-1:0] XSTAT_BASE   = 32'h0000_030E;
  localparam logic [WORD_W-1:0] CTRL_VALUE   = 32'h0000_0003;
endpackage

// File: rtl/muart_rx_fifo.sv
module muart_rx_fifo
  import muart_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  input  logic              pop_req,
  input  logic              flush_req,
  output logic [BYTE_W-1:0] head_byte,
  output logic [CNT_W-1:0]  fill
);
  logic [BYTE_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  rd_ptr;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W:0]    slot_sum;
  logic [PTR_W-1:0]  wr_slot;
  logic              do_push, do_pop, not_empty;

  assign not_empty = (cnt != '0);
  assign in_ready  = (cnt != CNT_W'(DEPTH));
  assign do_push   = in_valid && in_ready && !flush_req;
  assign do_pop    = pop_req && not_empty && !flush_req;

  always_comb begin
    slot_sum = (CNT_W+1)'(rd_ptr) + (CNT_W+1)'(cnt);
    if (slot_sum >= (CNT_W+1)'(DEPTH))
      slot_sum = slot_sum - (CNT_W+1)'(DEPTH);
    wr_slot = slot_sum[PTR_W-1:0];
  end

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) store[wr_slot] <= in_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush_req) begin
      cnt <= '0;
    end else begin
      if (do_pop)
        rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  assign head_byte = store[rd_ptr];
  assign fill      = cnt;

  a_r5_fill_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush_req |=> cnt == '0);
  a_r6_empty_read_holds: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !not_empty && !in_valid && !flush_req) |=> (rd_ptr == $past(rd_ptr)) && (cnt == '0));
  a_r4_push_grows: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !pop_req && !flush_req) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/muart_status.sv
module muart_status
  import muart_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0]  fill,
  input  logic [1:0]        inten,
  output logic              pending,
  output logic [WORD_W-1:0] inten_word,
  output logic [WORD_W-1:0] intid_word,
  output logic [WORD_W-1:0] line_word,
  output logic [WORD_W-1:0] xstat_word
);
  logic has_data, rx_pend, tx_pend;

  assign has_data = (fill != '0);
  assign rx_pend  = inten[0] && has_data;
  assign tx_pend  = inten[1];
  assign pending  = rx_pend || tx_pend;

  always_comb begin
    inten_word = FIFO_EN_BITS | WORD_W'(inten);

    intid_word = FIFO_EN_BITS;
    // receive has priority over transmit in the id field
    intid_word[2] = has_data;
    intid_word[1] = !has_data;
    intid_word[0] = !pending;

    line_word    = LINE_BASE;
    line_word[0] = has_data;

    xstat_word    = XSTAT_BASE;
    xstat_word[0] = has_data;
    xstat_word[16 +: CNT_W] = fill;
  end
endmodule

// File: rtl/muart_regs.sv
module muart_regs
  import muart_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              irq
);
  logic [IDX_W-1:0]  widx;
  logic              rd_hit, wr_hit;
  logic              pop_req, flush_req;
  logic [1:0]        inten_q;
  logic [BYTE_W-1:0] head_byte;
  logic [CNT_W-1:0]  fill;
  logic              pending;
  logic [WORD_W-1:0] inten_word, intid_word, line_word, xstat_word;
  logic [WORD_W-1:0] rd_mux;

  assign widx      = bus_addr[ADDR_W-1:2];
  assign rd_hit    = bus_sel && !bus_wr;
  assign wr_hit    = bus_sel && bus_wr;
  assign pop_req   = rd_hit && (widx == IDX_W'(IX_DATA));
  assign flush_req = wr_hit && (widx == IDX_W'(IX_INTID)) && bus_wdata[1];

  muart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (rx_valid),
    .in_byte   (rx_data),
    .in_ready  (rx_ready),
    .pop_req   (pop_req),
    .flush_req (flush_req),
    .head_byte (head_byte),
    .fill      (fill)
  );

  muart_status #(.CNT_W(CNT_W)) u_status (
    .fill       (fill),
    .inten      (inten_q),
    .pending    (pending),
    .inten_word (inten_word),
    .intid_word (intid_word),
    .line_word  (line_word),
    .xstat_word (xstat_word)
  );

  always_comb begin
    unique case (widx)
      IDX_W'(IX_IRQSUM): rd_mux = WORD_W'(pending);
      IDX_W'(IX_ENABLE): rd_mux = 32'd1;
      IDX_W'(IX_DATA):   rd_mux = WORD_W'(head_byte);
      IDX_W'(IX_INTEN):  rd_mux = inten_word;
      IDX_W'(IX_INTID):  rd_mux = intid_word;
      IDX_W'(IX_LINEST): rd_mux = line_word;
      IDX_W'(IX_CTRL):   rd_mux = CTRL_VALUE;
      IDX_W'(IX_XSTAT):  rd_mux = xstat_word;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inten_q    <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      tx_data    <= '0;
      tx_valid   <= 1'b0;
      irq        <= 1'b0;
    end else begin
      bus_rvalid <= rd_hit;
      if (rd_hit) bus_rdata <= rd_mux;
      tx_valid <= wr_hit && (widx == IDX_W'(IX_DATA));
      if (wr_hit && (widx == IDX_W'(IX_DATA))) tx_data <= bus_wdata[7:0];
      if (wr_hit && (widx == IDX_W'(IX_INTEN))) inten_q <= bus_wdata[1:0];
      irq <= pending;
    end
  end

  a_r2_tx_follows_write: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && widx == IDX_W'(IX_DATA)) |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));
  a_r13_read_answered: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> bus_rvalid);
  a_r11_tx_enable_irq: assert property (@(posedge clk) disable iff (rst)
    inten_q[1] |=> irq);
  a_r5_full_not_ready: assert property (@(posedge clk) disable iff (rst)
    (fill == CNT_W'(DEPTH)) |-> !rx_ready);
endmodule

// File: tb/test_muart_regs.sv
module test_muart_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] rd_q[$];
  string       rd_tag[$];
  logic [7:0]  tx_q[$];

  always #2 clk = ~clk;

  muart_regs i_muart_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // monitors sample at the falling edge
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (rd_q.size() == 0) chk(1'b0, "R13 unexpected read response", bus_rdata, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = rd_q.pop_front();
        t = rd_tag.pop_front();
        chk(bus_rdata === e, t, bus_rdata, e);
      end
    end
    if (!rst && tx_valid) begin
      if (tx_q.size() == 0) chk(1'b0, "R2 unexpected transmit strobe", {24'h0, tx_data}, 32'h0);
      else begin
        logic [7:0] e;
        e = tx_q.pop_front();
        chk(tx_data === e, "R2 transmit byte", {24'h0, tx_data}, {24'h0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    finish_run();
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    if (a == 8'h40) tx_q.push_back(d[7:0]);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    rd_q.push_back(exp);
    rd_tag.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rx(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(irq == 1'b0, "R1 irq after reset", {31'h0, irq}, 32'h0);
    chk(rx_ready == 1'b1, "R1 rx_ready after reset", {31'h0, rx_ready}, 32'h1);
    chk(tx_valid == 1'b0, "R1 tx_valid after reset", {31'h0, tx_valid}, 32'h0);
    rd(8'h44, 32'hC0, "R1 enables clear");
    rd(8'h54, 32'h60, "R9 line status empty");
    rd(8'h64, 32'h30E, "R10 extended status empty");
    rd(8'h48, 32'hC3, "R7 id empty no pending");

    // R2 transmit
    wr(8'h40, 32'h5A);
    wr(8'h40, 32'h1A5);
    settle();

    // R3 / R11 transmit interrupt
    wr(8'h44, 32'hFF);
    rd(8'h44, 32'hC3, "R3 enable bits masked");
    settle();
    chk(irq == 1'b1, "R11 tx enable raises irq", {31'h0, irq}, 32'h1);
    rd(8'h00, 32'h1, "R11 summary pending");
    rd(8'h48, 32'hC2, "R7 id empty tx pending");
    wr(8'h44, 32'h0);
    settle();
    chk(irq == 1'b0, "R11 irq drops", {31'h0, irq}, 32'h0);
    rd(8'h00, 32'h0, "R11 summary idle");

    // R4 order, R7 priority, R11 rx interrupt
    rx(8'h11); rx(8'h22); rx(8'h33);
    rd(8'h54, 32'h61, "R9 line status data");
    rd(8'h64, 32'h0003_030F, "R10 fill three");
    rd(8'h48, 32'hC5, "R7 id data no pending");
    chk(irq == 1'b0, "R11 data without rx enable", {31'h0, irq}, 32'h0);
    wr(8'h44, 32'h1);
    settle();
    chk(irq == 1'b1, "R11 rx interrupt", {31'h0, irq}, 32'h1);
    rd(8'h48, 32'hC4, "R7 id data pending");
    rd(8'h40, 32'h11, "R4 first byte");
    rd(8'h40, 32'h22, "R4 second byte");
    rd(8'h40, 32'h33, "R4 third byte");
    settle();
    chk(irq == 1'b0, "R11 rx interrupt clears", {31'h0, irq}, 32'h0);
    rd(8'h48, 32'hC3, "R7 id empty rx enabled");

    // R5 fill to depth, with pointer wrap
    for (int i = 0; i < 8; i++) rx(8'h80 + 8'(i));
    chk(rx_ready == 1'b0, "R5 ready low when full", {31'h0, rx_ready}, 32'h0);
    rx(8'h88);
    rd(8'h64, 32'h0008_030F, "R5 fill stays at depth");
    for (int i = 0; i < 8; i++) rd(8'h40, 32'h80 + i, "R5 full drain order");
    chk(rx_ready == 1'b1, "R5 ready after drain", {31'h0, rx_ready}, 32'h1);

    // R6 empty read
    rd(8'h40, 32'h80, "R6 stale head on empty read");
    rd(8'h64, 32'h30E, "R6 no underflow");
    rx(8'h99);
    rd(8'h40, 32'h99, "R6 head unchanged");
    wr(8'h44, 32'h0);

    // R8 flush
    rx(8'hAA); rx(8'hBB);
    wr(8'h48, 32'h2);
    rd(8'h64, 32'h30E, "R8 flush empties");
    rx(8'hCC); rx(8'hDD);
    wr(8'h48, 32'h4);
    rd(8'h64, 32'h0002_030F, "R8 bit1 clear no flush");
    rd(8'h40, 32'hCC, "R8 content kept");
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h48; bus_wdata = 32'h2;
    rx_valid = 1'b1; rx_data = 8'hEE;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; rx_valid = 1'b0;
    rd(8'h64, 32'h30E, "R8 flush beats push");
    rx(8'h77);
    rd(8'h40, 32'h77, "R8 data after flush");

    // R12 constants and ignored writes
    wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h58, 32'hFFFF_FFFF);
    wr(8'h5C, 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h68, 32'hFFFF_FFFF);
    wr(8'h04, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h04, 32'h1, "R12 enables reads one");
    rd(8'h60, 32'h3, "R12 control reads three");
    rd(8'h4C, 32'h0, "R12 line control zero");
    rd(8'h50, 32'h0, "R12 modem control zero");
    rd(8'h58, 32'h0, "R12 modem status zero");
    rd(8'h5C, 32'h0, "R12 scratch zero");
    rd(8'h68, 32'h0, "R12 baud zero");
    rd(8'h80, 32'h0, "R12 unmapped zero");
    rd(8'hFC, 32'h0, "R12 last word zero");
    rd(8'h44, 32'hC0, "R12 enables untouched");
    rd(8'h64, 32'h30E, "R12 fifo untouched");
    settle();
    chk(irq == 1'b0, "R12 irq untouched", {31'h0, irq}, 32'h0);

    repeat (4) @(negedge clk);
    chk(rd_q.size() == 0, "R13 every read answered", rd_q.size(), 32'h0);
    chk(tx_q.size() == 0, "R2 every data write sent", tx_q.size(), 32'h0);
    finish_run();
  end
endmodule